// File: doc/BRIEF.md
# Wide Unsigned Multiply-Add Unit

This block computes A*B + C on unsigned 64-bit operands. It keeps the full 128-bit product, adds the third operand zero-extended to 128 bits, and returns the sum as two 64-bit words: the lower half on one result port and the upper half on the other. It changes no flags and has no status outputs beyond its handshake.

The arithmetic is done by a radix-2 shift-add sequencer, one multiplier bit per clock. A single-cycle pulse on `start` while the unit is idle captures all three operands. The unit then raises `busy` and works through the multiplier bits. After the last bit it copies the sum into the result registers and pulses `done`. The result registers keep their value until the next operation completes. A user issues one operation at a time and reads both halves when `done` is seen.

Top module: `mac_wide_unit`

## Requirements
- R1: A synchronous active-high reset clears `busy`, `done`, `resLo` and `resHi` to zero.
- R2: On completion, `resLo` holds bits 63..0 of opA*opB + opC, with all three operands unsigned and opC zero-extended to 128 bits.
- R3: On completion, `resHi` holds bits 127..64 of that same 128-bit sum.
- R4: The sum never overflows 128 bits. All-ones operands give `resHi` = all ones and `resLo` = 0.
- R5: If `start` is sampled high at edge k while `busy` is low, `busy` is high from edge k through edge k+65 (65 cycles). `done` is high for exactly the one cycle after edge k+65 and is never high together with `busy`.
- R6: A `start` sampled while `busy` is high is ignored. It changes neither the result nor the completion time of the running operation.
- R7: Operands are captured only at the accepting edge. Changes on opA, opB and opC after that edge do not affect the result.
- R8: `resLo` and `resHi` change only at the edge that raises `done`. They hold their previous values through the whole of a later operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request; accepted only while idle |
| opA | input | 64 | Multiplicand |
| opB | input | 64 | Multiplier |
| opC | input | 64 | Addend, zero-extended |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| resLo | output | 64 | Low half of the sum |
| resHi | output | 64 | High half of the sum |

## Verification
The assertions assume that `rst` is held high for at least one clock edge before any operation. They also assume that `start` is a clean synchronous level, so that the latency counter in the checker starts from a known idle state. The bench asserts reset for several cycles first. It changes `start` and the operands only on falling edges. It deliberately pulses `start` in the middle of a run and scrambles the operands after acceptance, which exercises the ignore and capture rules without leaving those assumptions.

// File: rtl/mac_wide_pkg.sv
`timescale 1ns/1ps
package mac_wide_pkg;

  // Strobes from the sequencer to the arithmetic datapath
  typedef struct packed {
    logic load;    // capture operands, seed accumulator with addend
    logic step;    // process one multiplier bit
    logic finish;  // copy the sum into the result registers
  } macStrobes_t;

endpackage

// File: rtl/mac_wide_ctrl.sv
`timescale 1ns/1ps
module mac_wide_ctrl
  import mac_wide_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output macStrobes_t strb
);

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH);

  logic             busyQ;
  logic             doneQ;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    strb.load   = start && !busyQ;
    strb.step   = busyQ && (bitCnt != LAST);
    strb.finish = busyQ && (bitCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      bitCnt <= '0;
    end else begin
      doneQ <= strb.finish;
      if (strb.load) begin
        busyQ  <= 1'b1;
        bitCnt <= '0;
      end else if (strb.step) begin
        bitCnt <= bitCnt + 1'b1;
      end else if (strb.finish) begin
        busyQ <= 1'b0;
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

endmodule

// File: rtl/mac_wide_dp.sv
`timescale 1ns/1ps
module mac_wide_dp
  import mac_wide_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  macStrobes_t      strb,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  output logic [WIDTH-1:0] resLo,
  output logic [WIDTH-1:0] resHi
);

  // Working register pair {hiAcc, loShift}: the upper half starts as the
  // addend and the lower half as the multiplier. After WIDTH shift-add
  // steps the pair holds A*B + C.
  logic [WIDTH-1:0] mcandQ;
  logic [WIDTH-1:0] hiAcc;
  logic [WIDTH-1:0] loShift;
  logic [WIDTH:0]   partSum;
  logic [WIDTH-1:0] resLoQ;
  logic [WIDTH-1:0] resHiQ;

  always_comb begin
    partSum = {1'b0, hiAcc} + (loShift[0] ? {1'b0, mcandQ} : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcandQ  <= '0;
      hiAcc   <= '0;
      loShift <= '0;
    end else if (strb.load) begin
      mcandQ  <= opA;
      hiAcc   <= opC;
      loShift <= opB;
    end else if (strb.step) begin
      hiAcc   <= partSum[WIDTH:1];
      loShift <= {partSum[0], loShift[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resLoQ <= '0;
      resHiQ <= '0;
    end else if (strb.finish) begin
      resLoQ <= loShift;
      resHiQ <= hiAcc;
    end
  end

  assign resLo = resLoQ;
  assign resHi = resHiQ;

endmodule

// File: rtl/mac_wide_unit.sv
`timescale 1ns/1ps
module mac_wide_unit
  import mac_wide_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] resLo,
  output logic [WIDTH-1:0] resHi
);

  macStrobes_t strb;

  mac_wide_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .strb  (strb)
  );

  mac_wide_dp #(.WIDTH(WIDTH)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .opA   (opA),
    .opB   (opB),
    .opC   (opC),
    .resLo (resLo),
    .resHi (resHi)
  );

endmodule

// File: rtl/mac_wide_checker.sv
`timescale 1ns/1ps
module mac_wide_checker #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] resLo,
  input logic [WIDTH-1:0] resHi
);

  localparam int RC_W = $clog2(WIDTH + 2) + 1;
  localparam logic [RC_W-1:0] RUN_LEN = RC_W'(WIDTH + 1);

  // Counts consecutive busy cycles; equals the run length while done is high
  logic [RC_W-1:0] runCnt;
  always_ff @(posedge clk) begin
    if (rst)       runCnt <= '0;
    else if (busy) runCnt <= runCnt + 1'b1;
    else           runCnt <= '0;
  end

  // R1: reset clears handshake and results
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!busy && !done && resLo == '0 && resHi == '0));

  // R5: done lasts one cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: done and busy never together
  a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  // R5/R6: completion comes exactly WIDTH+1 busy cycles after acceptance
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> runCnt == RUN_LEN);

  // R8: results only change at the edge that raises done
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(resLo) && $stable(resHi)));

endmodule

bind mac_wide_unit mac_wide_checker #(.WIDTH(WIDTH)) u_checker (
  .clk   (clk),
  .rst   (rst),
  .busy  (busy),
  .done  (done),
  .resLo (resLo),
  .resHi (resHi)
);

// File: tb/mac_wide_unit_bench.sv
`timescale 1ns/1ps
module mac_wide_unit_bench;

  localparam int W = 64;
  localparam int LATENCY = W + 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] opC = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] resLo;
  logic [W-1:0] resHi;

  int errors = 0;
  int checks = 0;
  int cycleNo = 0;
  logic [W-1:0] prevLo = '0;
  logic [W-1:0] prevHi = '0;

  mac_wide_unit #(.WIDTH(W)) u_mac_wide_unit (
    .clk(clk), .rst(rst), .start(start),
    .opA(opA), .opB(opB), .opC(opC),
    .busy(busy), .done(done), .resLo(resLo), .resHi(resHi)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycleNo++;
    if (cycleNo > 20000) begin
      errors++;
      $display("FAIL R5 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 busy", 128'(busy), 128'(0));
    check("R1 done", 128'(done), 128'(0));
    check("R1 resLo", 128'(resLo), 128'(0));
    check("R1 resHi", 128'(resHi), 128'(0));
  endtask

  // Runs one operation. injectBusy pulses start mid-run with other operands (R6).
  // Operands are scrambled right after acceptance (R7).
  task automatic runOp(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] c, input bit injectBusy);
    logic [127:0] expSum;
    int cycles;
    expSum = (128'(a) * 128'(b)) + 128'(c);
    @(negedge clk);
    start = 1'b1; opA = a; opB = b; opC = c;
    @(negedge clk);
    start = 1'b0; opA = ~a ^ 64'h5a5a; opB = b + 64'd3; opC = ~c;
    check({tag, " R5 busy after accept"}, 128'(busy), 128'(1));
    cycles = 0;
    while (!done && cycles < 200) begin
      @(negedge clk);
      cycles++;
      start = injectBusy && (cycles == 10);
      if (cycles == 30) begin
        check({tag, " R8 hold lo during run"}, 128'(resLo), 128'(prevLo));
        check({tag, " R8 hold hi during run"}, 128'(resHi), 128'(prevHi));
      end
    end
    start = 1'b0;
    check({tag, " R5 latency"}, 128'(cycles), 128'(LATENCY));
    check({tag, " R5 busy low at done"}, 128'(busy), 128'(0));
    check({tag, " R2 R7 low half"}, 128'(resLo), 128'(expSum[63:0]));
    check({tag, " R3 R7 high half"}, 128'(resHi), 128'(expSum[127:64]));
    @(negedge clk);
    check({tag, " R5 done one cycle"}, 128'(done), 128'(0));
    check({tag, " R8 hold lo after"}, 128'(resLo), 128'(expSum[63:0]));
    prevLo = expSum[63:0];
    prevHi = expSum[127:64];
  endtask

  task automatic testMax();
    runOp("max", '1, '1, '1, 1'b0);
    check("R4 max high all ones", 128'(resHi), 128'({W{1'b1}}));
    check("R4 max low zero", 128'(resLo), 128'(0));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    runOp("small", 64'd3, 64'd5, 64'd7, 1'b0);
    runOp("addend only", 64'd0, 64'hffff_0000_1234_5678, 64'h8000_0000_0000_0001, 1'b0);
    runOp("mixed", 64'hdead_beef_0bad_f00d, 64'h1234_5678_9abc_def1, 64'hffff_ffff_ffff_ffff, 1'b0);
    runOp("R6 ignore", 64'h0000_0001_0000_0003, 64'h8000_0000_0000_0005, 64'd42, 1'b1);
    testMax();
    runOp("one", 64'd1, 64'hffff_ffff_ffff_ffff, 64'd1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule